// File: doc/BRIEF.md
# General-purpose pin port with per-pin interrupt detection

This block is one port of general-purpose pins (32 by default) behind a flat 32-bit register window. Software programs each pin as an input or an output, drives output levels either with a whole-word write or through write-only set and clear aliases, and reads the pin levels after a two-flop synchroniser. The set and clear aliases change individual output bits without a read-modify-write sequence, so two agents can own different pins of the same port.

Every pin can also raise an interrupt. Three per-pin configuration bits pick the trigger: a level/edge select, a sense bit (high or rising when 0, low or falling when 1) and a both-edges bit that, in edge mode, overrides the sense bit. Enabled pins latch a status bit when their trigger fires; software clears status bits by writing ones to a clear alias. A mask bit hides a pin from the single interrupt output without stopping it from latching. Pull-enable, pull-direction, debounce-enable and debounce-prescale words are plain storage; the pull words are brought out to the pad ring.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, `pin_out`, `pin_oe`, both pad pull outputs and `irq` are 0.
- R2: The direction word at offset 0x08 drives `pin_oe`; bit value 1 makes that pin an output, 0 an input.
- R3: A write to offset 0x00 loads the whole output word, read back at 0x00 and driven on `pin_out`; a write to offset 0x10 sets each output bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: A write to offset 0x14 clears each output bit whose write-data bit is 1 and leaves bits written with 0 unchanged; reads of 0x10 and 0x14 return 0.
- R5: Offset 0x04 returns `pin_in` after a two-flop synchroniser; writes to 0x04 have no effect.
- R6: With its trigger-type bit (offset 0x34) at 1 a pin is level sensitive; its sense bit (offset 0x3C) at 0 makes high active and at 1 makes low active, and the status bit is set again after a clear while the level stays active.
- R7: With its trigger-type bit at 0 and both-edge bit at 0 a pin latches status on a rising edge when its sense bit is 0 and on a falling edge when it is 1.
- R8: With its trigger-type bit at 0 and both-edge bit (offset 0x38) at 1 a pin latches status on either edge whatever its sense bit.
- R9: Status bits (read at offset 0x24) are set only for pins whose enable bit (offset 0x20) is 1.
- R10: Writing a 1 to a bit at offset 0x30 clears that status bit, writing 0 leaves it; 0x30 reads 0.
- R11: `irq` is 1 exactly when some status bit is 1 with its mask bit (offset 0x2C) at 0; a masked pin still latches status.
- R12: Pull enable (0x18), pull direction (0x1C, 1 = pull up), debounce enable (0x40) and debounce prescale (0x44) read back what was written; the two pull words drive `pad_pull_en` and `pad_pull_up`; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 = up |
| irq | output | 1 | Port interrupt, OR of unmasked pending pins |

## Verification
The bench builds the block with its defaults: 32 pins, an 8-bit offset, a 32-bit data word and two synchroniser stages. With 32 pins on one word the low six pins can each carry a different trigger setting at once (rising, falling, both edges, level high, level low and one disabled pin), so a single input change exercises every detector side by side and shows cross-pin independence. Keeping the pin count equal to the data width puts the top pins on the word boundary, where the output set and clear aliases and the wide input patterns are checked.

// File: rtl/gpio_bank_pkg.sv
// Shared offsets and trigger helpers for the pin port.
// Assumes word-aligned byte offsets within an 8-bit window.
package gpio_bank_pkg;

    localparam logic [7:0] OFS_DOUT  = 8'h00;
    localparam logic [7:0] OFS_DIN   = 8'h04;
    localparam logic [7:0] OFS_DIR   = 8'h08;
    localparam logic [7:0] OFS_DSET  = 8'h10;
    localparam logic [7:0] OFS_DCLR  = 8'h14;
    localparam logic [7:0] OFS_PEN   = 8'h18;
    localparam logic [7:0] OFS_PUP   = 8'h1C;
    localparam logic [7:0] OFS_IEN   = 8'h20;
    localparam logic [7:0] OFS_ISTAT = 8'h24;
    localparam logic [7:0] OFS_IMSK  = 8'h2C;
    localparam logic [7:0] OFS_ICLR  = 8'h30;
    localparam logic [7:0] OFS_ITYP  = 8'h34;
    localparam logic [7:0] OFS_IBOTH = 8'h38;
    localparam logic [7:0] OFS_ISNS  = 8'h3C;
    localparam logic [7:0] OFS_DBEN  = 8'h40;
    localparam logic [7:0] OFS_DBPS  = 8'h44;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_kind_e;

    // Resolve the three configuration bits of one pin into a trigger kind.
    function automatic trig_kind_e trig_kind(input logic lvl, input logic both,
                                             input logic sense);
        if (lvl)       return TRIG_LEVEL;
        else if (both) return TRIG_BOTH;
        else if (sense) return TRIG_FALL;
        else           return TRIG_RISE;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Input synchroniser for the pin port.
// Passes each pin through STAGES flops and keeps one extra delayed copy so
// that downstream logic can detect edges. Assumes STAGES >= 2.
module gpio_bank_sync #(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_now,
    output logic [NUM_PINS-1:0] pin_prev
);

    localparam int unsigned CHAIN = STAGES + 1;

    logic [NUM_PINS-1:0] chain_q [CHAIN];

    generate
        for (genvar s = 0; s < CHAIN; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= pin_async;
                end
            end else begin : g_next
                // Following synchroniser or history flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_now  = chain_q[STAGES-1];
    assign pin_prev = chain_q[STAGES];

    // R5: the history copy is the synchronised value one cycle late
    a_r5_history_lag: assert property (@(posedge clk) disable iff (!rst_n)
        pin_prev == $past(pin_now))
        else $error("a_r5_history_lag");

endmodule

// File: rtl/gpio_bank_regs.sv
// Register file and read mux of the pin port.
// Holds every software-visible word, applies the set/clear aliases to the
// output word and produces a one-cycle clear vector for the status logic.
// Assumes NUM_PINS <= DATA_W and one access per cycle.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] din,
    input  logic [NUM_PINS-1:0] stat,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] pen_q,
    output logic [NUM_PINS-1:0] pup_q,
    output logic [NUM_PINS-1:0] ien_q,
    output logic [NUM_PINS-1:0] imsk_q,
    output logic [NUM_PINS-1:0] ityp_q,
    output logic [NUM_PINS-1:0] iboth_q,
    output logic [NUM_PINS-1:0] isns_q,
    output logic [NUM_PINS-1:0] clr_bits
);

    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] dben_q;
    logic [DATA_W-1:0]   dbps_q;

    // Decode one write-enable per offset.
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wbits = reg_wdata[NUM_PINS-1:0];

    // Clear vector for the status bits: only during a write to the clear alias.
    assign clr_bits = (reg_wr && hit(reg_addr, OFS_ICLR)) ? wbits : '0;

    // Output word with whole-word load and per-bit set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, OFS_DOUT))      dout_q <= wbits;
            else if (hit(reg_addr, OFS_DSET)) dout_q <= dout_q | wbits;
            else if (hit(reg_addr, OFS_DCLR)) dout_q <= dout_q & ~wbits;
        end
    end

    // Direction, pull and interrupt configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            pen_q   <= '0;
            pup_q   <= '0;
            ien_q   <= '0;
            imsk_q  <= '0;
            ityp_q  <= '0;
            iboth_q <= '0;
            isns_q  <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, OFS_DIR))   dir_q   <= wbits;
            if (hit(reg_addr, OFS_PEN))   pen_q   <= wbits;
            if (hit(reg_addr, OFS_PUP))   pup_q   <= wbits;
            if (hit(reg_addr, OFS_IEN))   ien_q   <= wbits;
            if (hit(reg_addr, OFS_IMSK))  imsk_q  <= wbits;
            if (hit(reg_addr, OFS_ITYP))  ityp_q  <= wbits;
            if (hit(reg_addr, OFS_IBOTH)) iboth_q <= wbits;
            if (hit(reg_addr, OFS_ISNS))  isns_q  <= wbits;
        end
    end

    // Debounce storage words, kept only for software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dben_q <= '0;
            dbps_q <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, OFS_DBEN)) dben_q <= wbits;
            if (hit(reg_addr, OFS_DBPS)) dbps_q <= reg_wdata;
        end
    end

    // Read mux; aliases and unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_DOUT):  reg_rdata = DATA_W'(dout_q);
            ADDR_W'(OFS_DIN):   reg_rdata = DATA_W'(din);
            ADDR_W'(OFS_DIR):   reg_rdata = DATA_W'(dir_q);
            ADDR_W'(OFS_PEN):   reg_rdata = DATA_W'(pen_q);
            ADDR_W'(OFS_PUP):   reg_rdata = DATA_W'(pup_q);
            ADDR_W'(OFS_IEN):   reg_rdata = DATA_W'(ien_q);
            ADDR_W'(OFS_ISTAT): reg_rdata = DATA_W'(stat);
            ADDR_W'(OFS_IMSK):  reg_rdata = DATA_W'(imsk_q);
            ADDR_W'(OFS_ITYP):  reg_rdata = DATA_W'(ityp_q);
            ADDR_W'(OFS_IBOTH): reg_rdata = DATA_W'(iboth_q);
            ADDR_W'(OFS_ISNS):  reg_rdata = DATA_W'(isns_q);
            ADDR_W'(OFS_DBEN):  reg_rdata = DATA_W'(dben_q);
            ADDR_W'(OFS_DBPS):  reg_rdata = dbps_q;
            default:            reg_rdata = '0;
        endcase
    end

    // R3: bits written as ones through the set alias are high next cycle
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit(reg_addr, OFS_DSET)) |=>
            ((dout_q & $past(wbits)) == $past(wbits)))
        else $error("a_r3_set_alias");

    // R4: bits written as ones through the clear alias are low next cycle
    a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit(reg_addr, OFS_DCLR)) |=> ((dout_q & $past(wbits)) == '0))
        else $error("a_r4_clear_alias");

    // R4: zero bits of either alias leave the output word unchanged
    a_r4_alias_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (hit(reg_addr, OFS_DSET) || hit(reg_addr, OFS_DCLR))) |=>
            ((dout_q & ~$past(wbits)) == ($past(dout_q) & ~$past(wbits))))
        else $error("a_r4_alias_keeps");

endmodule

// File: rtl/gpio_bank_irq.sv
// Per-pin trigger detection, status latching and interrupt output.
// Each pin resolves its level/edge/both/sense configuration, latches a
// status bit while enabled, drops it on a write-one clear unless the trigger
// is present in the same cycle, and the unmasked status bits form irq.
// Assumes cur/prev come from the synchroniser (prev = cur one cycle late).
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prev,
    input  logic [NUM_PINS-1:0] ien,
    input  logic [NUM_PINS-1:0] imsk,
    input  logic [NUM_PINS-1:0] ityp,
    input  logic [NUM_PINS-1:0] iboth,
    input  logic [NUM_PINS-1:0] isns,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] status_q,
    output logic                irq
);

    logic [NUM_PINS-1:0] trig;
    logic [NUM_PINS-1:0] set_bits;
    logic [NUM_PINS-1:0] pend;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            // Trigger detector for one pin, chosen by its configuration.
            always_comb begin
                unique case (trig_kind(ityp[p], iboth[p], isns[p]))
                    TRIG_LEVEL: trig[p] = cur[p] ^ isns[p];
                    TRIG_BOTH:  trig[p] = cur[p] ^ prev[p];
                    TRIG_FALL:  trig[p] = prev[p] & ~cur[p];
                    default:    trig[p] = cur[p] & ~prev[p];
                endcase
            end
        end
    endgenerate

    assign set_bits = trig & ien;

    // Status latch: a present trigger wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | set_bits;
    end

    assign pend = status_q & ~imsk;

    // Single port interrupt line.
    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) irq = irq | pend[i];
    end

    // R9: a disabled pin never turns its status bit on
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ien)) == '0))
        else $error("a_r9_disabled_quiet");

    // R7: an enabled trigger is latched on the next edge
    a_r7_trigger_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig & ien) & ~status_q) == '0))
        else $error("a_r7_trigger_latched");

    // R10: a cleared bit without a coincident trigger reads zero next cycle
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((status_q & $past(clr & ~set_bits)) == '0))
        else $error("a_r10_clear_drops");

    // R11: with every pin masked the interrupt line stays low
    a_r11_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&imsk) |-> !irq)
        else $error("a_r11_all_masked");

    // R11: the interrupt line is never raised without a pending status bit
    a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0))
        else $error("a_r11_irq_has_cause");

endmodule

// File: rtl/gpio_bank.sv
// General-purpose pin port with per-pin interrupt detection.
// Ties the register file, the input synchroniser and the trigger/status
// logic together and drives the pad-side outputs. Assumes a single clock,
// synchronous active-low reset and NUM_PINS <= DATA_W.
module gpio_bank #(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pad_pull_en,
    output logic [NUM_PINS-1:0] pad_pull_up,
    output logic                irq
);

    logic [NUM_PINS-1:0] pin_now;
    logic [NUM_PINS-1:0] pin_prev;
    logic [NUM_PINS-1:0] stat;
    logic [NUM_PINS-1:0] ien;
    logic [NUM_PINS-1:0] imsk;
    logic [NUM_PINS-1:0] ityp;
    logic [NUM_PINS-1:0] iboth;
    logic [NUM_PINS-1:0] isns;
    logic [NUM_PINS-1:0] clr_bits;

    gpio_bank_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_now   (pin_now),
        .pin_prev  (pin_prev)
    );

    gpio_bank_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .din       (pin_now),
        .stat      (stat),
        .dout_q    (pin_out),
        .dir_q     (pin_oe),
        .pen_q     (pad_pull_en),
        .pup_q     (pad_pull_up),
        .ien_q     (ien),
        .imsk_q    (imsk),
        .ityp_q    (ityp),
        .iboth_q   (iboth),
        .isns_q    (isns),
        .clr_bits  (clr_bits)
    );

    gpio_bank_irq #(
        .NUM_PINS (NUM_PINS)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (pin_now),
        .prev     (pin_prev),
        .ien      (ien),
        .imsk     (imsk),
        .ityp     (ityp),
        .iboth    (iboth),
        .isns     (isns),
        .clr      (clr_bits),
        .status_q (stat),
        .irq      (irq)
    );

    // R1: the port comes out of reset with outputs released and no interrupt
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq))
        else $error("a_r1_reset_quiet");

endmodule

// File: tb/gpio_bank_bench.sv
// Scoreboard bench: the driver queues expected values, the monitor compares
// them against the port at the falling clock edge.
module gpio_bank_bench;

    localparam int unsigned N  = 32;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3, K_PEN = 4, K_PUP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, pad_pull_en, pad_pull_up;
    logic          irq;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic  chk = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #4 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic expect_val(input int kind, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        chk = 1'b1;
        @(posedge clk); #1;
        chk = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(posedge clk); #1;
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    // Monitor: pop one expected item per strobe and compare.
    always @(negedge clk) begin
        if (chk && sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_IRQ:   act = {31'd0, irq};
                K_OUT:   act = pin_out;
                K_OE:    act = pin_oe;
                K_PEN:   act = pad_pull_en;
                K_PUP:   act = pad_pull_up;
                default: act = reg_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %08h expected %08h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_val(K_RD,  8'h00, 32'h0, "R1 output word");
        expect_val(K_RD,  8'h08, 32'h0, "R1 direction word");
        expect_val(K_RD,  8'h24, 32'h0, "R1 status word");
        expect_val(K_IRQ, 8'h00, 32'h0, "R1 irq");
        expect_val(K_OE,  8'h00, 32'h0, "R1 pin_oe");
        expect_val(K_PEN, 8'h00, 32'h0, "R1 pad_pull_en");

        // R2 direction
        wr(8'h08, 32'h0000_FFFF);
        expect_val(K_OE, 8'h00, 32'h0000_FFFF, "R2 pin_oe");
        expect_val(K_RD, 8'h08, 32'h0000_FFFF, "R2 direction readback");

        // R3 / R4 output word and aliases
        wr(8'h00, 32'h1234_5678);
        expect_val(K_RD,  8'h00, 32'h1234_5678, "R3 whole-word load");
        wr(8'h10, 32'h8F00_0000);
        expect_val(K_RD,  8'h00, 32'h9F34_5678, "R3 set alias");
        wr(8'h14, 32'h8000_0078);
        expect_val(K_RD,  8'h00, 32'h1F34_5600, "R4 clear alias");
        expect_val(K_OUT, 8'h00, 32'h1F34_5600, "R4 pin_out");
        expect_val(K_RD,  8'h10, 32'h0, "R4 set alias reads zero");
        expect_val(K_RD,  8'h14, 32'h0, "R4 clear alias reads zero");

        // R5 input sampling, write ignored
        pins(32'hA5A5_0000);
        expect_val(K_RD, 8'h04, 32'hA5A5_0000, "R5 input word");
        wr(8'h04, 32'hFFFF_FFFF);
        expect_val(K_RD, 8'h04, 32'hA5A5_0000, "R5 input write ignored");
        expect_val(K_RD, 8'h00, 32'h1F34_5600, "R5 input write leaves output");

        // Interrupt setup: p0 rise, p1 fall, p2 both, p3 level high,
        // p4 level low, p5 rise but disabled.
        pins(32'h0000_0012);
        wr(8'h34, 32'h0000_0018);
        wr(8'h3C, 32'h0000_0016);
        wr(8'h38, 32'h0000_0004);
        wr(8'h20, 32'h0000_001F);
        wr(8'h30, 32'hFFFF_FFFF);
        expect_val(K_RD,  8'h24, 32'h0, "R10 all cleared");
        expect_val(K_IRQ, 8'h00, 32'h0, "R11 idle irq");

        // p0 rise, p1 fall, p2 rise, p5 rise
        pins(32'h0000_0035);
        expect_val(K_RD,  8'h24, 32'h0000_0007, "R7 R8 R9 edges latched");
        expect_val(K_IRQ, 8'h00, 32'h1, "R11 irq raised");
        wr(8'h30, 32'h0000_0007);
        expect_val(K_RD,  8'h24, 32'h0, "R10 edge status cleared");
        expect_val(K_IRQ, 8'h00, 32'h0, "R11 irq dropped");

        // p0 fall (no), p1 rise (no), p2 fall (yes)
        pins(32'h0000_0032);
        expect_val(K_RD, 8'h24, 32'h0000_0004, "R8 both-edge fall, R7 wrong edges ignored");
        wr(8'h30, 32'h0000_0004);

        // level high on p3 survives a clear
        pins(32'h0000_003A);
        expect_val(K_RD, 8'h24, 32'h0000_0008, "R6 level high latched");
        wr(8'h30, 32'h0000_0008);
        expect_val(K_RD, 8'h24, 32'h0000_0008, "R6 level re-sets after clear");
        pins(32'h0000_0032);
        wr(8'h30, 32'h0000_0008);
        expect_val(K_RD, 8'h24, 32'h0, "R6 level gone, clear sticks");

        // level low on p4, mask behaviour
        pins(32'h0000_0022);
        expect_val(K_RD,  8'h24, 32'h0000_0010, "R6 level low latched");
        wr(8'h2C, 32'h0000_0010);
        expect_val(K_IRQ, 8'h00, 32'h0, "R11 masked pin hidden");
        expect_val(K_RD,  8'h24, 32'h0000_0010, "R11 masked status kept");
        wr(8'h2C, 32'h0000_0000);
        expect_val(K_IRQ, 8'h00, 32'h1, "R11 unmasked irq");
        pins(32'h0000_0032);
        wr(8'h30, 32'h0000_0000);
        expect_val(K_RD,  8'h24, 32'h0000_0010, "R10 zero clear bits keep status");
        wr(8'h30, 32'hFFFF_FFFF);
        expect_val(K_RD,  8'h24, 32'h0, "R10 clear all");

        // masked pin still latches
        wr(8'h2C, 32'hFFFF_FFFF);
        pins(32'h0000_0033);
        expect_val(K_RD,  8'h24, 32'h0000_0001, "R11 masked pin latches");
        expect_val(K_IRQ, 8'h00, 32'h0, "R11 all masked irq low");

        // R12 storage words
        wr(8'h18, 32'hDEAD_0001);
        wr(8'h1C, 32'h0000_BEEF);
        wr(8'h40, 32'h0000_0003);
        wr(8'h44, 32'h0000_1234);
        expect_val(K_RD,  8'h18, 32'hDEAD_0001, "R12 pull enable readback");
        expect_val(K_RD,  8'h1C, 32'h0000_BEEF, "R12 pull type readback");
        expect_val(K_RD,  8'h40, 32'h0000_0003, "R12 debounce enable readback");
        expect_val(K_RD,  8'h44, 32'h0000_1234, "R12 debounce prescale readback");
        expect_val(K_PEN, 8'h00, 32'hDEAD_0001, "R12 pad_pull_en");
        expect_val(K_PUP, 8'h00, 32'h0000_BEEF, "R12 pad_pull_up");
        expect_val(K_RD,  8'h48, 32'h0, "R12 unmapped offset");
        expect_val(K_RD,  8'h30, 32'h0, "R10 clear alias reads zero");

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule